// File: doc/BRIEF.md
# Three-Bank Rotating Sample Buffer

This block sits between a streaming sample source, an engine that transforms a block of samples in place, and a sink that drains finished blocks. It owns three equal banks of sample memory. At every moment one bank is being filled by the source, one is being read and overwritten by the engine, and one is being read out by the sink. Filling, transforming and draining all run at the same time on three different blocks of data.

Each side raises a one-cycle completion pulse when it has finished with its bank. Once all three sides have finished, the roles move one step. The bank just transformed is handed to the sink. The bank just filled is handed to the engine. The bank just drained is handed back to the source. A 2-bit rotation index shows the current assignment. The block steers each side's address, data and enables to the correct bank, so no side needs to know which physical bank it is using.

Each word is a complex sample with 16-bit real and 16-bit imaginary halves packed into 32 bits. The bank depth is a parameter; a full bank for two 2048-point symbols is 4096 words.

Top module: `tribank_xform_buf`

## Requirements
- R1: After reset, rotIdx is 0 and prodReady, engReady and consReady are all 1.
- R2: A word the source writes at address A, while it is ready, is returned to the engine by a read of address A after the next rotation.
- R3: Read data for an engine or sink read request accepted at a clock edge is valid on engRdData or consRdData right after that edge, and stays valid until the next edge.
- R4: The engine's writes replace the contents of its bank in place. When the engine reads and writes the same address in one cycle, the read returns the value held before the write.
- R5: After a side pulses its done input, that side's ready output is 0 until the next rotation has completed. Writes and reads that the side issues while its ready is 0 are ignored and leave the bank contents unchanged.
- R6: A rotation starts only once all three done flags are set. In the cycle after the third done pulse, all ready outputs are 0. At the end of that cycle rotIdx advances and every flag clears.
- R7: Repeating a done pulse from a side whose flag is already set has no effect: no rotation happens, and the other sides' ready outputs do not change.
- R8: rotIdx steps 0→1→2→0. For index r, the source fills bank r, the sink reads bank (r+1) mod 3, and the engine works on bank (r+2) mod 3. As a result, engine output reaches the sink at the same address after the next rotation.
- R9: engRdData and consRdData hold their values in any cycle with no accepted read on that side and no rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prodWrEn | input | 1 | Source write request |
| prodAddr | input | ADDR_W | Source write address |
| prodData | input | DATA_W | Source write data (real in upper half, imaginary in lower half) |
| prodDone | input | 1 | Source completion pulse |
| prodReady | output | 1 | Source may access its bank |
| engRdEn | input | 1 | Engine read request |
| engRdAddr | input | ADDR_W | Engine read address |
| engRdData | output | DATA_W | Engine read data, one cycle after the request |
| engWrEn | input | 1 | Engine write request |
| engWrAddr | input | ADDR_W | Engine write address |
| engWrData | input | DATA_W | Engine write data |
| engDone | input | 1 | Engine completion pulse |
| engReady | output | 1 | Engine may access its bank |
| consRdEn | input | 1 | Sink read request |
| consRdAddr | input | ADDR_W | Sink read address |
| consRdData | output | DATA_W | Sink read data, one cycle after the request |
| consDone | input | 1 | Sink completion pulse |
| consReady | output | 1 | Sink may access its bank |
| rotIdx | output | 2 | Current role assignment index (0, 1 or 2) |

## Verification
The main flow is tried over five consecutive blocks, each block written with a different seed, so that a given address holds a different value in every bank. A data mix-up between banks or an off-by-one role mapping then appears as a value mismatch, not as a coincidental match. Engine checks show that source data moves forward by exactly one role per rotation. Sink checks show that the engine's in-place result moves forward by one more. Directed cases then separate the order of the done pulses, duplicate pulses, access attempts while not ready, same-address read-and-write in one cycle, and the index wrap from 2 to 0.

// File: rtl/tribank_pkg.sv
package tribank_pkg;

  typedef struct packed {
    logic       prodWr;
    logic       engRd;
    logic       engWr;
    logic       consRd;
    logic [1:0] rot;
  } tbStrobes_t;

  function automatic logic [1:0] rotNext(input logic [1:0] r);
    return (r == 2'd2) ? 2'd0 : r + 2'd1;
  endfunction

  function automatic logic [1:0] fillBank(input logic [1:0] r);
    return r;
  endfunction

  function automatic logic [1:0] drainBank(input logic [1:0] r);
    return rotNext(r);
  endfunction

  function automatic logic [1:0] workBank(input logic [1:0] r);
    return (r == 2'd0) ? 2'd2 : r - 2'd1;
  endfunction

endpackage

// File: rtl/tribank_bank.sv
module tribank_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic              re,
  input  logic [AW-1:0]     rAddr,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first: a same-cycle write to rAddr is not seen by this read
  always_ff @(posedge clk) begin
    if (re) q <= mem[rAddr];
    if (we) mem[wAddr] <= wData;
  end

endmodule

// File: rtl/tribank_ctrl.sv
module tribank_ctrl
  import tribank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       prodWrEn,
  input  logic       prodDone,
  input  logic       engRdEn,
  input  logic       engWrEn,
  input  logic       engDone,
  input  logic       consRdEn,
  input  logic       consDone,
  output logic       prodReady,
  output logic       engReady,
  output logic       consReady,
  output logic [1:0] rotIdx,
  output tbStrobes_t strb
);

  // flag bit 0 source, bit 1 engine, bit 2 sink
  logic [2:0] doneFlags;
  logic [1:0] rotQ;
  logic       allDone;

  assign allDone = &doneFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlags <= '0;
      rotQ      <= 2'd0;
    end else if (allDone) begin
      doneFlags <= '0;
      rotQ      <= rotNext(rotQ);
    end else begin
      doneFlags <= doneFlags | {consDone, engDone, prodDone};
    end
  end

  assign prodReady = !doneFlags[0];
  assign engReady  = !doneFlags[1];
  assign consReady = !doneFlags[2];
  assign rotIdx    = rotQ;

  always_comb begin
    strb.prodWr = prodWrEn && prodReady;
    strb.engRd  = engRdEn  && engReady;
    strb.engWr  = engWrEn  && engReady;
    strb.consRd = consRdEn && consReady;
    strb.rot    = rotQ;
  end

  AST_ROT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rotIdx != 2'd3);  // R6

  AST_ROT_ONLY_ALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rotIdx) |-> $past(prodReady == 1'b0 && engReady == 1'b0 && consReady == 1'b0));  // R6

  AST_ROT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rotIdx) |-> (rotIdx == rotNext($past(rotIdx))));  // R8

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (prodDone && prodReady) |=> !prodReady);  // R5

  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rotIdx) |-> (prodReady && engReady && consReady));  // R6

endmodule

// File: rtl/tribank_datapath.sv
module tribank_datapath
  import tribank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbStrobes_t        strb,
  input  logic [AW-1:0]     prodAddr,
  input  logic [DATA_W-1:0] prodData,
  input  logic [AW-1:0]     engRdAddr,
  input  logic [AW-1:0]     engWrAddr,
  input  logic [DATA_W-1:0] engWrData,
  input  logic [AW-1:0]     consRdAddr,
  output logic [DATA_W-1:0] engRdData,
  output logic [DATA_W-1:0] consRdData
);

  localparam int NBANK = 3;

  logic [1:0] fillSel, workSel, drainSel;
  logic [DATA_W-1:0] bankQ [NBANK];
  logic [NBANK-1:0] prodWeVec, engWeVec;

  assign fillSel  = fillBank(strb.rot);
  assign workSel  = workBank(strb.rot);
  assign drainSel = drainBank(strb.rot);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              weB, reB, fromProd, toEng;
    logic [AW-1:0]     wAddrB, rAddrB;
    logic [DATA_W-1:0] wDataB;

    assign fromProd     = (fillSel == 2'(b));
    assign toEng        = (workSel == 2'(b));
    assign prodWeVec[b] = strb.prodWr && fromProd;
    assign engWeVec[b]  = strb.engWr  && toEng;
    assign weB    = prodWeVec[b] || engWeVec[b];
    assign wAddrB = fromProd ? prodAddr : engWrAddr;
    assign wDataB = fromProd ? prodData : engWrData;
    assign reB    = (strb.engRd && toEng) || (strb.consRd && (drainSel == 2'(b)));
    assign rAddrB = toEng ? engRdAddr : consRdAddr;

    tribank_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (weB),
      .wAddr (wAddrB),
      .wData (wDataB),
      .re    (reB),
      .rAddr (rAddrB),
      .q     (bankQ[b])
    );
  end

  always_comb begin
    case (workSel)
      2'd0:    engRdData = bankQ[0];
      2'd1:    engRdData = bankQ[1];
      default: engRdData = bankQ[2];
    endcase
    case (drainSel)
      2'd0:    consRdData = bankQ[0];
      2'd1:    consRdData = bankQ[1];
      default: consRdData = bankQ[2];
    endcase
  end

  AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (prodWeVec & engWeVec) == '0);  // R8

  AST_ONE_SINK_READ_ROLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drainSel == workSel, drainSel == fillSel, workSel == fillSel}) &&
    !(drainSel == workSel));  // R8

  AST_CONS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.consRd |=> ($stable(consRdData) || !$stable(strb.rot)));  // R9

  AST_ENG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.engRd |=> ($stable(engRdData) || !$stable(strb.rot)));  // R9

endmodule

// File: rtl/tribank_xform_buf.sv
module tribank_xform_buf
  import tribank_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BANK_WORDS = 256,
  localparam int ADDR_W    = $clog2(BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prodWrEn,
  input  logic [ADDR_W-1:0] prodAddr,
  input  logic [DATA_W-1:0] prodData,
  input  logic              prodDone,
  output logic              prodReady,
  input  logic              engRdEn,
  input  logic [ADDR_W-1:0] engRdAddr,
  output logic [DATA_W-1:0] engRdData,
  input  logic              engWrEn,
  input  logic [ADDR_W-1:0] engWrAddr,
  input  logic [DATA_W-1:0] engWrData,
  input  logic              engDone,
  output logic              engReady,
  input  logic              consRdEn,
  input  logic [ADDR_W-1:0] consRdAddr,
  output logic [DATA_W-1:0] consRdData,
  input  logic              consDone,
  output logic              consReady,
  output logic [1:0]        rotIdx
);

  tbStrobes_t strb;

  tribank_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .prodWrEn  (prodWrEn),
    .prodDone  (prodDone),
    .engRdEn   (engRdEn),
    .engWrEn   (engWrEn),
    .engDone   (engDone),
    .consRdEn  (consRdEn),
    .consDone  (consDone),
    .prodReady (prodReady),
    .engReady  (engReady),
    .consReady (consReady),
    .rotIdx    (rotIdx),
    .strb      (strb)
  );

  tribank_datapath #(.DATA_W(DATA_W), .DEPTH(BANK_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .prodAddr   (prodAddr),
    .prodData   (prodData),
    .engRdAddr  (engRdAddr),
    .engWrAddr  (engWrAddr),
    .engWrData  (engWrData),
    .consRdAddr (consRdAddr),
    .engRdData  (engRdData),
    .consRdData (consRdData)
  );

endmodule

// File: tb/tribank_xform_buf_test.sv
`timescale 1ns/1ps
module tribank_xform_buf_test;

  localparam int DATA_W = 32;
  localparam int WORDS  = 16;
  localparam int AW     = $clog2(WORDS);
  localparam int NF     = 5;
  localparam logic [31:0] XK = 32'h5A5A_A5A5;
  localparam logic [31:0] SEEDS [NF] = '{32'h1000_2000, 32'h3333_0101, 32'hC0DE_0007,
                                         32'h0BAD_F00D, 32'h7E57_1234};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic prodWrEn = 0, prodDone = 0, engRdEn = 0, engWrEn = 0, engDone = 0;
  logic consRdEn = 0, consDone = 0;
  logic [AW-1:0] prodAddr = '0, engRdAddr = '0, engWrAddr = '0, consRdAddr = '0;
  logic [DATA_W-1:0] prodData = '0, engWrData = '0;
  logic [DATA_W-1:0] engRdData, consRdData;
  logic prodReady, engReady, consReady;
  logic [1:0] rotIdx;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  tribank_xform_buf #(.DATA_W(DATA_W), .BANK_WORDS(WORDS)) uut (
    .clk(clk), .rstN(rstN),
    .prodWrEn(prodWrEn), .prodAddr(prodAddr), .prodData(prodData), .prodDone(prodDone),
    .prodReady(prodReady),
    .engRdEn(engRdEn), .engRdAddr(engRdAddr), .engRdData(engRdData),
    .engWrEn(engWrEn), .engWrAddr(engWrAddr), .engWrData(engWrData),
    .engDone(engDone), .engReady(engReady),
    .consRdEn(consRdEn), .consRdAddr(consRdAddr), .consRdData(consRdData),
    .consDone(consDone), .consReady(consReady), .rotIdx(rotIdx)
  );

  function automatic logic [31:0] pat(input int k, input int a);
    return SEEDS[k] + 32'(a) * 32'h0001_0003;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic prodWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    prodWrEn = 1; prodAddr = AW'(a); prodData = d;
    @(negedge clk);
    prodWrEn = 0;
  endtask

  task automatic engRead(input int a, output logic [31:0] d);
    @(negedge clk);
    engRdEn = 1; engRdAddr = AW'(a);
    @(negedge clk);
    engRdEn = 0;
    d = engRdData;
  endtask

  task automatic engWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    engWrEn = 1; engWrAddr = AW'(a); engWrData = d;
    @(negedge clk);
    engWrEn = 0;
  endtask

  task automatic consRead(input int a, output logic [31:0] d);
    @(negedge clk);
    consRdEn = 1; consRdAddr = AW'(a);
    @(negedge clk);
    consRdEn = 0;
    d = consRdData;
  endtask

  task automatic pulse(input int side);
    @(negedge clk);
    if (side == 0) prodDone = 1; else if (side == 1) engDone = 1; else consDone = 1;
    @(negedge clk);
    prodDone = 0; engDone = 0; consDone = 0;
  endtask

  // third pulse, then check the swap cycle and the new index
  task automatic finishRotation(input logic [1:0] expRot);
    pulse(2);
    check("R6 readies low in swap cycle", {prodReady, engReady, consReady}, 3'b000);
    @(negedge clk);
    check("R6 R8 rotIdx after rotation", rotIdx, expRot);
    check("R6 readies back after rotation", {prodReady, engReady, consReady}, 3'b111);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] valA, valB, valC;
    repeat (3) @(negedge clk);
    check("R1 reset rotIdx", rotIdx, 2'd0);
    check("R1 reset readies", {prodReady, engReady, consReady}, 3'b111);
    rstN = 1;
    @(negedge clk);

    // table walk: each block passes through fill, work and drain roles
    for (int k = 0; k < NF; k++) begin
      for (int a = 0; a < WORDS; a++) prodWrite(a, pat(k, a));
      if (k >= 1) begin
        for (int a = 0; a < WORDS; a++) begin
          engRead(a, d);
          check("R2 R3 engine sees previous block", d, pat(k - 1, a));
          engWrite(a, d ^ XK);
        end
      end
      if (k >= 2) begin
        for (int a = 0; a < WORDS; a++) begin
          consRead(a, d);
          check("R8 R3 sink sees transformed block", d, pat(k - 2, a) ^ XK);
        end
      end
      pulse(0);
      pulse(1);
      finishRotation(2'((k + 1) % 3));
    end

    // R5 R7: rotIdx is now 2 (five rotations)
    valA = 32'hAAAA_0001;
    valB = 32'hBBBB_0002;
    valC = 32'hCCCC_0003;
    prodWrite(0, valA);
    pulse(0);
    check("R5 prodReady low after done", prodReady, 1'b0);
    prodWrite(0, valB);
    pulse(1);
    pulse(1);
    check("R7 duplicate engine done no rotation", rotIdx, 2'd2);
    check("R7 sink still ready", consReady, 1'b1);
    repeat (2) @(negedge clk);
    check("R6 no rotation with two flags", rotIdx, 2'd2);
    finishRotation(2'd0);
    engRead(0, d);
    check("R5 ignored write left bank intact", d, valA);

    // R4: same-cycle read and write to one address
    @(negedge clk);
    engRdEn = 1; engRdAddr = '0; engWrEn = 1; engWrAddr = '0; engWrData = valC;
    @(negedge clk);
    engRdEn = 0; engWrEn = 0;
    check("R4 read-first on same address", engRdData, valA);
    engRead(0, d);
    check("R4 in-place overwrite", d, valC);

    // R9: hold without reads
    repeat (3) @(negedge clk);
    check("R9 engine read data held", engRdData, valC);

    // R8: the engine result moves to the sink on the next rotation
    pulse(0);
    pulse(1);
    finishRotation(2'd1);
    consRead(0, d);
    check("R8 in-place result reaches sink", d, valC);
    repeat (2) @(negedge clk);
    check("R9 sink read data held", consRdData, valC);

    // R1: reset in the middle of a run
    pulse(1);
    rstN = 0;
    @(negedge clk);
    check("R1 mid-run reset rotIdx", rotIdx, 2'd0);
    check("R1 mid-run reset readies", {prodReady, engReady, consReady}, 3'b111);
    rstN = 1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule